// File: doc/BRIEF.md
# I/Q Input Formatter

This block sits between a complex-baseband sample source and an interpolator. It takes 18-bit I and Q words and presents them as one aligned pair, always in two's complement, with a one-cycle valid pulse. Data is taken only on cycles where the sample-enable input is high. That enable comes from an external pacing divider.

Two static capture modes are supported. In dual-bus mode, both buses are sampled together on an enabled cycle. In interleaved mode, only the I bus carries data: a strobed word is the I half and the next enabled unstrobed word is the Q half.

A static format input selects offset-binary input. Offset-binary input is converted by inverting the top bit.

The interleaved capture is a two-state machine:

- `SEEK_I` is the idle state, waiting for a strobed word.
  - Transition `grab_i`: an enabled strobed word moves it to `HOLD_I`.
  - Transition `drop_orphan`: an enabled unstrobed word is discarded and the state stays `SEEK_I`.
- `HOLD_I` holds an I word and waits for its partner.
  - Transition `emit_pair`: an enabled unstrobed word completes the pair and returns the machine to `SEEK_I`.
  - Transition `regrab_i`: an enabled strobed word replaces the held I and the state stays `HOLD_I`.
- Transition `force_seek`: dual-bus mode forces the machine to `SEEK_I`.

Top module: `iq_input_formatter`

## Requirements
- R1: After reset, `pair_vld` is 0 and `pair_i` and `pair_q` are 0.
- R2: In dual-bus mode (`ser_mode`=0), an enabled cycle captures `i_bus` and `q_bus`. The converted words appear on `pair_i`/`pair_q` one clock later, with `pair_vld` high for that single cycle.
- R3: On a cycle with `sample_en`=0, nothing is captured. `pair_vld` is low on the next cycle and `pair_i`/`pair_q` keep their values.
- R4: In interleaved mode (`ser_mode`=1), an enabled word with `i_strb`=1 is held as I. The next enabled word with `i_strb`=0 is the Q word, and the pair is presented one clock after that Q word with a single-cycle `pair_vld`. Non-enabled cycles may lie between the two words.
- R5: In interleaved mode, `q_bus` has no effect on any output.
- R6: In interleaved mode, an enabled unstrobed word with no held I word is discarded and produces no `pair_vld`.
- R7: In interleaved mode, a strobed word arriving while an I word is held replaces it. The next Q word pairs with the newer I word.
- R8: With `ofs_bin`=1, bit 17 (the MSB) of every word is inverted and bits 16:0 pass unchanged. With `ofs_bin`=0, words pass unchanged.
- R9: In dual-bus mode, `i_strb` has no effect.
- R10: In interleaved mode, `pair_vld` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode | input | 1 | 1 = interleaved single-bus capture, 0 = dual-bus capture |
| ofs_bin | input | 1 | 1 = input words are offset binary |
| sample_en | input | 1 | Input-enable pulse; data is taken only when high |
| i_strb | input | 1 | Marks the I word in interleaved mode |
| i_bus | input | 18 | I word, or interleaved I/Q words |
| q_bus | input | 18 | Q word (dual-bus mode only) |
| pair_vld | output | 1 | One-cycle pulse: a new pair is on the outputs |
| pair_i | output | 18 | I output, two's complement |
| pair_q | output | 18 | Q output, two's complement |

## Verification
Dual-bus samples are sent with gaps in the enable and with the strobe toggling. This separates correct enable qualification from free-running capture, and shows the strobe is ignored in that mode.

Interleaved pairs are sent with junk on the Q bus and idle cycles between the halves. Leading orphan Q words and back-to-back strobed words are also sent. Together these distinguish true strobe framing from plain alternation, and newest-I pairing from oldest-I pairing.

Both number formats are run with the extreme codes 0x00000, 0x1FFFF, 0x20000 and 0x3FFFF. These expose a missing or misplaced MSB inversion.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
    localparam int SAMPLE_W = 18;

    typedef enum logic {
        SEEK_I = 1'b0,
        HOLD_I = 1'b1
    } pair_state_e;
endpackage

// File: rtl/iqf_fmt_conv.sv
module iqf_fmt_conv #(
    parameter int W = 18
) (
    input  logic         ofs_bin,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);
    localparam int MSB = W - 1;

    always_comb begin
        word_out      = word_in;
        word_out[MSB] = word_in[MSB] ^ ofs_bin;
    end
endmodule

// File: rtl/iqf_pair_ctrl.sv
module iqf_pair_ctrl
    import iqf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_mode,
    input  logic        sample_en,
    input  logic        i_strb,
    output logic        take_i,
    output logic        take_pair,
    output pair_state_e state_o
);
    pair_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEEK_I;
        else        state_q <= state_d;
    end

    // Next state and action outputs
    always_comb begin
        state_d   = state_q;
        take_i    = 1'b0;
        take_pair = 1'b0;
        if (!ser_mode) begin
            state_d   = SEEK_I;            // force_seek
            take_pair = sample_en;
        end else begin
            unique case (state_q)
                SEEK_I: begin
                    if (sample_en && i_strb) begin
                        take_i  = 1'b1;    // grab_i
                        state_d = HOLD_I;
                    end                    // else drop_orphan
                end
                HOLD_I: begin
                    if (sample_en && i_strb) begin
                        take_i  = 1'b1;    // regrab_i
                    end else if (sample_en) begin
                        take_pair = 1'b1;  // emit_pair
                        state_d   = SEEK_I;
                    end
                end
                default: state_d = SEEK_I;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/iq_input_formatter.sv
module iq_input_formatter
    import iqf_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_mode,
    input  logic         ofs_bin,
    input  logic         sample_en,
    input  logic         i_strb,
    input  logic [W-1:0] i_bus,
    input  logic [W-1:0] q_bus,
    output logic         pair_vld,
    output logic [W-1:0] pair_i,
    output logic [W-1:0] pair_q
);
    logic [W-1:0] i_conv, q_conv, i_held;
    logic         take_i, take_pair;
    pair_state_e  state;

    iqf_fmt_conv #(.W(W)) u_conv_i (.ofs_bin(ofs_bin), .word_in(i_bus), .word_out(i_conv));
    iqf_fmt_conv #(.W(W)) u_conv_q (.ofs_bin(ofs_bin), .word_in(q_bus), .word_out(q_conv));

    iqf_pair_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_mode  (ser_mode),
        .sample_en (sample_en),
        .i_strb    (i_strb),
        .take_i    (take_i),
        .take_pair (take_pair),
        .state_o   (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_held   <= '0;
            pair_vld <= 1'b0;
            pair_i   <= '0;
            pair_q   <= '0;
        end else begin
            pair_vld <= take_pair;
            if (take_i) i_held <= i_conv;
            if (take_pair) begin
                pair_i <= ser_mode ? i_held : i_conv;
                pair_q <= ser_mode ? i_conv : q_conv;
            end
        end
    end

    // Assertions
    assert_idle_no_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> !pair_vld);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(pair_i) && $stable(pair_q)));
    assert_dual_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && sample_en) |=> (pair_vld &&
            pair_q == {$past(q_bus[W-1]) ^ $past(ofs_bin), $past(q_bus[W-2:0])}));
    assert_dual_i_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && sample_en) |=>
            (pair_i == {$past(i_bus[W-1]) ^ $past(ofs_bin), $past(i_bus[W-2:0])}));
    assert_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && sample_en && !i_strb && state == HOLD_I) |=> pair_vld);
    assert_orphan_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && sample_en && !i_strb && state == SEEK_I) |=> !pair_vld);
    assert_vld_in_seek_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |-> (state == SEEK_I));
endmodule

// File: tb/iq_input_formatter_tb.sv
module iq_input_formatter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_mode = 1'b0, ofs_bin = 1'b0, sample_en = 1'b0, i_strb = 1'b0;
    logic [17:0] i_bus = '0, q_bus = '0;
    logic        pair_vld;
    logic [17:0] pair_i, pair_q;

    int checks = 0, fails = 0;
    logic [35:0] exp_q[$];
    logic [17:0] last_i = '0, last_q = '0, held_i = '0;
    logic        prev_vld = 1'b0;

    always #5 clk = ~clk;

    iq_input_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ofs_bin(ofs_bin),
        .sample_en(sample_en), .i_strb(i_strb), .i_bus(i_bus), .q_bus(q_bus),
        .pair_vld(pair_vld), .pair_i(pair_i), .pair_q(pair_q)
    );

    function automatic logic [17:0] cv(input logic [17:0] x, input logic f);
        return f ? {~x[17], x[16:0]} : x;
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic stb, input logic [17:0] iv, input logic [17:0] qv);
        @(negedge clk);
        sample_en = en; i_strb = stb; i_bus = iv; q_bus = qv;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 18'h15A5A ^ 18'(k), 18'h2C3C3 + 18'(k));
    endtask

    // R2 R9: dual-bus sample, strobe value arbitrary
    task automatic par(input logic stb, input logic [17:0] iv, input logic [17:0] qv);
        drive(1'b1, stb, iv, qv);
        last_i = cv(iv, ofs_bin); last_q = cv(qv, ofs_bin);
        exp_q.push_back({last_i, last_q});
    endtask

    // R4 R5 R7: interleaved words; q_bus carries junk
    task automatic ser_i(input logic [17:0] iv);
        drive(1'b1, 1'b1, iv, ~iv);
        held_i = cv(iv, ofs_bin);
    endtask

    task automatic ser_q(input logic [17:0] qv);
        drive(1'b1, 1'b0, qv, 18'h3FFFF ^ qv);
        last_i = held_i; last_q = cv(qv, ofs_bin);
        exp_q.push_back({last_i, last_q});
    endtask

    task automatic set_mode(input logic s, input logic f);
        @(negedge clk);
        sample_en = 1'b0; ser_mode = s; ofs_bin = f;
        idle(2);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (pair_vld) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6/R3: unexpected pair %h_%h expected none", pair_i, pair_q);
                end else begin
                    check("R2/R4/R8 pair", {pair_i, pair_q}, exp_q.pop_front());
                end
            end
            if (ser_mode && prev_vld && pair_vld) begin
                checks++; fails++;
                $display("FAIL R10: actual back-to-back valid expected single pulse");
            end
            prev_vld = pair_vld;
        end
    end

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {17'b0, pair_vld, pair_i}, '0);
        check("R1 reset q", {18'b0, pair_q}, '0);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 R9 dual-bus, two's complement
        set_mode(1'b0, 1'b0);
        par(1'b0, 18'h00123, 18'h3FFFF);
        idle(2);
        par(1'b1, 18'h20000, 18'h1FFFF);   // R9 strobe high
        par(1'b0, 18'h0ABCD, 18'h35555);
        idle(3);
        check("R3 hold", {pair_i, pair_q}, {last_i, last_q});

        // R8 offset binary, dual-bus
        set_mode(1'b0, 1'b1);
        par(1'b1, 18'h00000, 18'h3FFFF);
        par(1'b0, 18'h20000, 18'h1FFFF);
        idle(1);

        // R4 R5 R6 interleaved, two's complement
        set_mode(1'b1, 1'b0);
        ser_q(18'h11111); void'(exp_q.pop_back());   // R6 orphan: nothing expected
        ser_i(18'h01234);
        idle(2);
        ser_q(18'h3ABCD);
        ser_i(18'h20000);
        ser_q(18'h1FFFF);
        idle(3);
        check("R3 hold serial", {pair_i, pair_q}, {last_i, last_q});

        // R7 re-strobe replaces held I
        ser_i(18'h0AAAA);
        ser_i(18'h05555);
        ser_q(18'h00F0F);
        idle(2);

        // R8 interleaved offset binary
        set_mode(1'b1, 1'b1);
        ser_i(18'h3FFFF);
        ser_q(18'h00000);
        ser_q(18'h22222); void'(exp_q.pop_back());   // R6 second orphan
        idle(3);

        check("R2/R4 scoreboard drained", 36'(exp_q.size()), '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule